// File: doc/BRIEF.md
# Protected Control Register with Slow-Domain Handshake

This block holds the control settings of a timekeeping unit in the fast bus clock domain and delivers three of them to a slow timekeeping clock domain: the master run enable, the time-of-day alarm enable and the sub-second alarm enable. Each delivery uses a toggle handshake, with a synchronizer in each direction. While a delivery is outstanding, or a newer value still waits to be sent, the block reports busy. The slow-domain copies only ever change through a completed handshake. Because of this, software knows that a change has taken hold once busy drops.

The master run enable is guarded. A write can change it only when the stored write-protect-release bit is already set and nothing is in flight. The register also carries a ready flag, which counter logic sets when it updates. It also carries a raw-read select that chooses whether counter reads are treated as synchronized or as free-running. The block combines these two into a read-valid indication. Out of reset, busy reads as 1, and the bus side starts a handshake by itself to load the default values.

Top module: `ctrl_xdom_sync`

## Requirements
- R1: Bit 0 (run enable) takes the written value only when the stored protect-release bit (bit 15, value before the write) is 1 and busy is 0; any other write leaves bit 0 unchanged.
- R2: The slow-domain outputs change only when a handshake arrives; once busy has fallen they equal readback bits 0 (run), 1 (time-of-day alarm enable) and 2 (sub-second alarm enable).
- R3: While reset is held and in the cycle after its release, readback is 0x00000008 and busy is 1; an automatic handshake then clears busy, and the slow outputs are 0.
- R4: A write that changes any of bits 2:0 raises busy in the next cycle; a write that changes none of them leaves busy at 0.
- R5: Writes to bits 2:1 made while busy are kept, and busy stays 1 until the latest value has been delivered, so no update is lost.
- R6: Bit 14 (raw read select) drives `raw_read_sel`; `cnt_rd_valid` is 1 when bit 14 is 1, and equals the ready bit otherwise.
- R7: Bit 4 (ready) is set by a `cnt_update` pulse, cleared by writing 0 and unaffected by writing 1; set wins when both occur in one cycle.
- R8: Bits 5, 8, 10:9, 14 and 15 read back as last written; bit 3 reads busy; bits 7:6, 13:11 and 31:16 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus domain clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| slow_clk | input | 1 | Timekeeping domain clock |
| slow_rst_n | input | 1 | Synchronous active-low reset, slow domain |
| wr_stb | input | 1 | Register write strobe (one bus cycle) |
| wr_data | input | 32 | Register write data |
| cnt_update | input | 1 | Pulse from counter logic marking a count update |
| rd_data | output | 32 | Register readback value |
| busy | output | 1 | Handshake outstanding or pending |
| raw_read_sel | output | 1 | Counter reads are free-running |
| cnt_rd_valid | output | 1 | Counter values may be read now |
| slow_run | output | 1 | Run enable, slow domain |
| slow_tod_alarm_en | output | 1 | Time-of-day alarm enable, slow domain |
| slow_sub_alarm_en | output | 1 | Sub-second alarm enable, slow domain |

## Verification
The bench tries to set the run enable while the protect bit is clear, and again while a transfer is busy with the protect bit set. A guard that looked at the wrong condition would let the enable flip, and it would then show in readback and in the slow copy. It changes an alarm enable a second time in the middle of a transfer; a design that dropped the pending value would leave busy low too early and hold the stale enable in the slow domain. It also checks the busy-at-reset value, the ready set/clear collision, and the raw-select effect on read validity.

// File: rtl/ctrl_xdom_pkg.sv
// Package: field positions and the shared type of the synchronized settings.
// Assumes a 32-bit register image.
package ctrl_xdom_pkg;
    localparam int REG_W     = 32;
    localparam int F_RUN     = 0;
    localparam int F_TOD     = 1;
    localparam int F_SUB     = 2;
    localparam int F_BUSY    = 3;
    localparam int F_RDY     = 4;
    localparam int F_RDYIE   = 5;
    localparam int F_SQW     = 8;
    localparam int F_FSEL_LO = 9;
    localparam int F_FSEL_HI = 10;
    localparam int F_RAW     = 14;
    localparam int F_WREL    = 15;

    // Settings carried to the slow domain; packed so bit 0 is run, bit 2 sub-second.
    typedef struct packed {
        logic sub;
        logic tod;
        logic run;
    } xctl_t;

    localparam int XCTL_W = $bits(xctl_t);
endpackage

// File: rtl/ctrl_sync_ff.sv
// Module: multi-stage synchronizer chain for a level or toggle signal.
// Assumes each bit is an independent toggle/level (no multi-bit coherence).
module ctrl_sync_ff #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Capture the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[g] <= '0;
                else        pipe[g] <= d;
            end
        end else begin : g_next
            // Shift through the remaining stages.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[g] <= '0;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/ctrl_bus_regs.sv
// Module: bus-side register image. It applies the write-protect rule to the
// run enable, keeps the ready flag and plain fields, and assembles readback.
// Assumes busy_i comes from the handshake launcher in the same clock domain.
module ctrl_bus_regs
    import ctrl_xdom_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [REG_W-1:0] wr_data,
    input  logic             cnt_update,
    input  logic             busy_i,
    output xctl_t            want_o,
    output logic [REG_W-1:0] rd_data,
    output logic             raw_sel_o,
    output logic             rd_valid_o
);
    xctl_t      want_q;
    logic       rdy_q, rdyie_q, sqw_q, raw_q, wrel_q;
    logic [1:0] fsel_q;
    logic       run_open;
    logic       unused_wr_bits;

    assign run_open       = wrel_q && !busy_i;
    assign unused_wr_bits = ^{wr_data[31:16], wr_data[13:11], wr_data[7:6], wr_data[3]};

    // Register the writable fields, guarding the run enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            want_q  <= '0;
            rdyie_q <= 1'b0;
            sqw_q   <= 1'b0;
            fsel_q  <= '0;
            raw_q   <= 1'b0;
            wrel_q  <= 1'b0;
        end else if (wr_stb) begin
            if (run_open) want_q.run <= wr_data[F_RUN];
            want_q.tod <= wr_data[F_TOD];
            want_q.sub <= wr_data[F_SUB];
            rdyie_q    <= wr_data[F_RDYIE];
            sqw_q      <= wr_data[F_SQW];
            fsel_q     <= wr_data[F_FSEL_HI:F_FSEL_LO];
            raw_q      <= wr_data[F_RAW];
            wrel_q     <= wr_data[F_WREL];
        end
    end

    // Ready flag: hardware set has priority over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                            rdy_q <= 1'b0;
        else if (cnt_update)                   rdy_q <= 1'b1;
        else if (wr_stb && !wr_data[F_RDY])    rdy_q <= 1'b0;
    end

    // Assemble the readback image.
    always_comb begin
        rd_data                     = '0;
        rd_data[F_RUN]              = want_q.run;
        rd_data[F_TOD]              = want_q.tod;
        rd_data[F_SUB]              = want_q.sub;
        rd_data[F_BUSY]             = busy_i;
        rd_data[F_RDY]              = rdy_q;
        rd_data[F_RDYIE]            = rdyie_q;
        rd_data[F_SQW]              = sqw_q;
        rd_data[F_FSEL_HI:F_FSEL_LO] = fsel_q;
        rd_data[F_RAW]              = raw_q;
        rd_data[F_WREL]             = wrel_q;
    end

    assign want_o     = want_q;
    assign raw_sel_o  = raw_q;
    assign rd_valid_o = raw_q | rdy_q;

    // R1: a write outside the open window never moves the run enable.
    a_r1_run_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !run_open) |=> (want_q.run == $past(want_q.run)));

    // R7: an update pulse always leaves ready set.
    a_r7_ready_set: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_update |=> rdy_q);
endmodule

// File: rtl/ctrl_hs_launch.sv
// Module: bus-side handshake launcher. It sends the wanted settings when they
// differ from the last sent copy (or after reset) and holds busy until the
// acknowledge toggle returns and nothing newer waits.
// Assumes ack_s is the synchronized acknowledge toggle from the slow side.
module ctrl_hs_launch
    import ctrl_xdom_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  xctl_t want_i,
    input  logic  ack_s,
    output logic  req_tgl,
    output xctl_t sent_o,
    output logic  busy_o
);
    xctl_t sent_q;
    logic  boot_q, inflight_q, need, ack_back;

    assign need     = boot_q || (want_i != sent_q);
    assign ack_back = (ack_s == req_tgl);
    assign busy_o   = inflight_q || need;
    assign sent_o   = sent_q;

    // Launch a transfer when idle and needed; retire it when the ack returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sent_q     <= '0;
            boot_q     <= 1'b1;
            inflight_q <= 1'b0;
            req_tgl    <= 1'b0;
        end else if (!inflight_q) begin
            if (need) begin
                sent_q     <= want_i;
                boot_q     <= 1'b0;
                inflight_q <= 1'b1;
                req_tgl    <= ~req_tgl;
            end
        end else if (ack_back) begin
            inflight_q <= 1'b0;
        end
    end

    // R3: busy is reported in the first cycle after reset.
    a_r3_busy_at_reset: assert property (@(posedge clk)
        !rst_n |=> busy_o);

    // R2: the sent copy holds still while a transfer is outstanding.
    a_r2_sent_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight_q && !ack_back) |=> $stable(sent_q));

    // R5: busy covers every outstanding transfer.
    a_r5_busy_covers: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q |-> busy_o);
endmodule

// File: rtl/ctrl_hs_capture.sv
// Module: slow-side handshake receiver. It captures the settings on a new
// request toggle and returns the toggle as the acknowledge.
// Assumes data_i is held stable by the launcher while the request is new.
module ctrl_hs_capture
    import ctrl_xdom_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  req_s,
    input  xctl_t data_i,
    output xctl_t ctl_o,
    output logic  ack_tgl
);
    xctl_t ctl_q;
    logic  take;

    assign take  = (req_s != ack_tgl);
    assign ctl_o = ctl_q;

    // Capture on a request edge and echo it back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            ack_tgl <= 1'b0;
        end else if (take) begin
            ctl_q   <= data_i;
            ack_tgl <= req_s;
        end
    end

    // R2: slow copies move only on a received request.
    a_r2_slow_only_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(ctl_q));
endmodule

// File: rtl/ctrl_xdom_sync.sv
// Module: top of the protected control register. It joins the bus register
// image, the launcher, the slow receiver and a synchronizer each way.
// Assumes both resets are asserted together, long enough to cover two slow edges.
module ctrl_xdom_sync
    import ctrl_xdom_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             bus_clk,
    input  logic             bus_rst_n,
    input  logic             slow_clk,
    input  logic             slow_rst_n,
    input  logic             wr_stb,
    input  logic [REG_W-1:0] wr_data,
    input  logic             cnt_update,
    output logic [REG_W-1:0] rd_data,
    output logic             busy,
    output logic             raw_read_sel,
    output logic             cnt_rd_valid,
    output logic             slow_run,
    output logic             slow_tod_alarm_en,
    output logic             slow_sub_alarm_en
);
    xctl_t want, sent, slow_ctl;
    logic  req_tgl, req_s, ack_tgl, ack_s, busy_w;

    ctrl_bus_regs u_regs (
        .clk(bus_clk), .rst_n(bus_rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .cnt_update(cnt_update), .busy_i(busy_w), .want_o(want),
        .rd_data(rd_data), .raw_sel_o(raw_read_sel), .rd_valid_o(cnt_rd_valid)
    );

    ctrl_hs_launch u_launch (
        .clk(bus_clk), .rst_n(bus_rst_n), .want_i(want), .ack_s(ack_s),
        .req_tgl(req_tgl), .sent_o(sent), .busy_o(busy_w)
    );

    ctrl_sync_ff #(.STAGES(SYNC_STAGES), .W(1)) u_req_sync (
        .clk(slow_clk), .rst_n(slow_rst_n), .d(req_tgl), .q(req_s)
    );

    ctrl_hs_capture u_capture (
        .clk(slow_clk), .rst_n(slow_rst_n), .req_s(req_s), .data_i(sent),
        .ctl_o(slow_ctl), .ack_tgl(ack_tgl)
    );

    ctrl_sync_ff #(.STAGES(SYNC_STAGES), .W(1)) u_ack_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(ack_tgl), .q(ack_s)
    );

    assign busy              = busy_w;
    assign slow_run          = slow_ctl.run;
    assign slow_tod_alarm_en = slow_ctl.tod;
    assign slow_sub_alarm_en = slow_ctl.sub;
endmodule

// File: tb/ctrl_xdom_sync_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module ctrl_xdom_sync_bench;
    localparam int BUS_PERIOD  = 10;
    localparam int SLOW_PERIOD = 70;

    logic        bus_clk = 1'b0, slow_clk = 1'b0;
    logic        bus_rst_n = 1'b0, slow_rst_n = 1'b0;
    logic        wr_stb = 1'b0, cnt_update = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        busy, raw_read_sel, cnt_rd_valid;
    logic        slow_run, slow_tod_alarm_en, slow_sub_alarm_en;
    int          checks = 0, failures = 0;
    bit          done = 1'b0;

    always #(BUS_PERIOD/2)  bus_clk  = ~bus_clk;
    always #(SLOW_PERIOD/2) slow_clk = ~slow_clk;

    ctrl_xdom_sync u_ctrl_xdom_sync (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .slow_clk(slow_clk),
        .slow_rst_n(slow_rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .cnt_update(cnt_update), .rd_data(rd_data), .busy(busy),
        .raw_read_sel(raw_read_sel), .cnt_rd_valid(cnt_rd_valid),
        .slow_run(slow_run), .slow_tod_alarm_en(slow_tod_alarm_en),
        .slow_sub_alarm_en(slow_sub_alarm_en)
    );

    task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, got, exp);
        end
    endtask

    task automatic bus_write(logic [31:0] v);
        @(negedge bus_clk);
        wr_stb  = 1'b1;
        wr_data = v;
        @(negedge bus_clk);
        wr_stb  = 1'b0;
    endtask

    task automatic wait_idle(string req);
        int n = 0;
        while (busy === 1'b1 && n < 200) begin
            @(negedge bus_clk);
            n++;
        end
        check(req, "busy clears", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_reset();
        repeat (20) @(negedge bus_clk);
        bus_rst_n  = 1'b1;
        slow_rst_n = 1'b1;
        @(negedge bus_clk);
        check("R3", "readback after reset", rd_data, 32'h0000_0008);
        check("R3", "busy after reset", {31'd0, busy}, 32'd1);
        wait_idle("R3");
        check("R3", "readback after boot", rd_data, 32'h0);
        check("R3", "slow outputs after boot",
              {29'd0, slow_sub_alarm_en, slow_tod_alarm_en, slow_run}, 32'h0);
    endtask

    task automatic t_protect_closed();
        bus_write(32'h0000_0001);
        check("R1", "run ignored with protect clear", rd_data, 32'h0);
        check("R4", "no busy without change", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_enable_run();
        bus_write(32'h0000_8000);
        check("R8", "protect bit reads back", rd_data, 32'h0000_8000);
        bus_write(32'h0000_8001);
        check("R4", "busy after run change", {31'd0, busy}, 32'd1);
        check("R2", "slow run not yet", {31'd0, slow_run}, 32'd0);
        wait_idle("R2");
        check("R1", "run set when open", rd_data, 32'h0000_8001);
        check("R2", "slow run delivered", {31'd0, slow_run}, 32'd1);
    endtask

    task automatic t_pending();
        bus_write(32'h0000_8007);
        check("R4", "busy on alarm change", {31'd0, busy}, 32'd1);
        bus_write(32'h0000_8002);
        check("R1", "run kept while busy", rd_data, 32'h0000_800B);
        wait_idle("R5");
        check("R5", "final readback", rd_data, 32'h0000_8003);
        check("R5", "slow carries latest",
              {29'd0, slow_sub_alarm_en, slow_tod_alarm_en, slow_run}, 32'h3);
    endtask

    task automatic t_protect_reclose();
        bus_write(32'h0000_0002);
        wait_idle("R1");
        check("R1", "run cleared while open", rd_data, 32'h0000_0002);
        check("R2", "slow run cleared", {31'd0, slow_run}, 32'd0);
        bus_write(32'h0000_0003);
        check("R1", "run ignored after protect closed", rd_data, 32'h0000_0002);
        check("R4", "busy stays low", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_fields();
        bus_write(32'h8000_47E2);
        check("R8", "plain fields and zero bits", rd_data, 32'h0000_4722);
        check("R6", "raw select out", {31'd0, raw_read_sel}, 32'd1);
        check("R6", "valid when raw", {31'd0, cnt_rd_valid}, 32'd1);
        bus_write(32'h0000_0002);
        check("R6", "raw select cleared", {31'd0, raw_read_sel}, 32'd0);
        check("R6", "invalid without ready", {31'd0, cnt_rd_valid}, 32'd0);
    endtask

    task automatic t_ready();
        @(negedge bus_clk);
        cnt_update = 1'b1;
        @(negedge bus_clk);
        cnt_update = 1'b0;
        check("R7", "ready set", rd_data, 32'h0000_0012);
        check("R6", "valid with ready", {31'd0, cnt_rd_valid}, 32'd1);
        bus_write(32'h0000_0012);
        check("R7", "write 1 keeps ready", rd_data, 32'h0000_0012);
        bus_write(32'h0000_0002);
        check("R7", "write 0 clears ready", rd_data, 32'h0000_0002);
        @(negedge bus_clk);
        cnt_update = 1'b1;
        wr_stb     = 1'b1;
        wr_data    = 32'h0000_0002;
        @(negedge bus_clk);
        cnt_update = 1'b0;
        wr_stb     = 1'b0;
        check("R7", "set wins over clear", rd_data, 32'h0000_0012);
    endtask

    initial begin
        t_reset();
        t_protect_closed();
        t_enable_run();
        t_pending();
        t_protect_reclose();
        t_fields();
        t_ready();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge bus_clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule